// File: doc/BRIEF.md
# EEPROM Configuration Loader

After reset this block fetches a list of configuration records from an external serial EEPROM and writes each one into the chip's internal register space, replacing the register defaults. It does not drive SCL or SDA itself. Instead it feeds a byte-level SMBus master engine through a command/response port. It also asks a bus arbiter for the master bus before every transaction, because a hot-plug I/O expander uses the same wires. The 7-bit EEPROM device address is formed from four strap pins, which are captured once when the active-low reset is released.

Each record is six bytes long: a 16-bit register address followed by a 32-bit data word, both stored most significant byte first. Record k sits at EEPROM byte address 6*k. The list ends at a record whose register address is all ones. If the EEPROM refuses a byte (NACK), loading stops and an error is flagged. A fixed record limit also ends the list if no end marker appears.

Once loading has finished, the slave side of the chip can send single-byte EEPROM read and write requests through a pass-through port. This allows the EEPROM to be reprogrammed in system. The streaming ports use valid/ready handshakes:
- A transfer happens on a clock edge where both valid and ready are high.
- A source holds valid and its payload unchanged until that edge.
- Control and status pins are plain levels.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: The device byte sent on the bus is {1,0,1,s3,s2,s1,s0,rw}, where s3..s0 are the strap pins sampled at the first clock edge after rst_n rises. Strap changes after that edge have no effect.
- R2: Loading starts after reset with no further stimulus. Each record is fetched by one transaction in this order:
  - START, write device byte with rw=0, write address high byte, write address low byte;
  - START, write device byte with rw=1;
  - five reads with ACK, one read with NACK;
  - STOP.
- R3: A record is presented on the register write port as (address, data) only after all six of its bytes have arrived. Records are presented in EEPROM order.
- R4: A record whose register address is 16'hFFFF ends loading with load_done=1 and load_err=0. That record is not written. load_done stays high until the next reset.
- R5: A NACK on any written byte makes the block send STOP and abandon the transaction. During loading this sets load_done=1 and load_err=1, and the record being fetched is not written.
- R6: After MAX_RECS records have been written with no end marker, loading ends with load_done=1 and load_err=1.
- R7: Command port rules:
  - cmd_op is coded 0=START, 1=WRITE byte, 2=READ with ACK, 3=READ with NACK, 4=STOP.
  - cmd_op and cmd_data hold steady while cmd_valid is high and cmd_ready is low.
  - Only one command is outstanding at a time: the next command is issued only after rsp_valid answers the previous one.
- R8: bus_req rises before the first command of a transaction. Commands are issued only while bus_gnt is high. bus_req falls after the STOP response, so it drops between any two transactions.
- R9: pt_req_ready stays low until load_done is high.
- R10: A pass-through write sends START, device byte with rw=0, address high, address low, the data byte, and STOP, then answers with pt_rsp_err=0.
- R11: A pass-through read sends START, device byte with rw=0, address high, address low, START, device byte with rw=1, one read with NACK, and STOP. It answers with the byte that was read.
- R12: A pass-through transaction that receives a NACK answers with pt_rsp_err=1. A response is held unchanged until pt_rsp_ready accepts it.
- R13: reg_wr_addr and reg_wr_data hold steady while reg_wr_valid is high and reg_wr_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; straps are captured on release |
| strap_addr | input | 4 | Device address straps (bits 4..1 of the device byte) |
| bus_req | output | 1 | Request for the shared master bus |
| bus_gnt | input | 1 | Grant from the bus arbiter; held while bus_req is held |
| cmd_valid | output | 1 | Command to the SMBus byte engine is valid |
| cmd_ready | input | 1 | Byte engine accepts the command |
| cmd_op | output | 3 | Command code (see R7) |
| cmd_data | output | 8 | Byte to transmit for WRITE commands |
| rsp_valid | input | 1 | One-cycle response to the last accepted command |
| rsp_nack | input | 1 | Slave did not acknowledge a written byte |
| rsp_data | input | 8 | Byte returned by a READ command |
| reg_wr_valid | output | 1 | Register write request valid |
| reg_wr_ready | input | 1 | Register write accepted |
| reg_wr_addr | output | REG_AW | Register address of the record |
| reg_wr_data | output | REG_DW | Register data of the record |
| pt_req_valid | input | 1 | Pass-through request valid |
| pt_req_ready | output | 1 | Pass-through request accepted |
| pt_req_write | input | 1 | 1 = write one byte, 0 = read one byte |
| pt_req_addr | input | 16 | EEPROM byte address |
| pt_req_wdata | input | 8 | Byte to write |
| pt_rsp_valid | output | 1 | Pass-through response valid |
| pt_rsp_ready | input | 1 | Pass-through response accepted |
| pt_rsp_rdata | output | 8 | Byte read (zero for writes) |
| pt_rsp_err | output | 1 | Transaction ended on a NACK |
| load_done | output | 1 | Initial load finished (sticky) |
| load_err | output | 1 | Initial load ended on a NACK or on the record limit |

## Verification
The embedded assertions check these properties on every cycle:
- the command, register-write and pass-through response payloads hold steady under back-pressure;
- the pass-through port stays closed until the load has finished;
- load_done never falls once set;
- the bus request is released when a transaction completes;
- the captured device address never moves after reset release.

Other behaviours can only be shown by the bench's scenarios against its EEPROM model:
- the exact byte order of a record fetch and of pass-through transactions;
- the device byte formed from the straps;
- which records reach the register port when a NACK or the record limit cuts loading short;
- the order in which records are written.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  // Byte-engine command codes (R7)
  typedef enum logic [2:0] {
    SMB_START     = 3'd0,
    SMB_WRITE     = 3'd1,
    SMB_READ_ACK  = 3'd2,
    SMB_READ_NACK = 3'd3,
    SMB_STOP      = 3'd4
  } smb_op_e;

  // Fixed upper bits of the device address: bits 7..5 of the device byte
  localparam logic [2:0] DEV_FIXED = 3'b101;
  localparam int STRAP_W = 4;
  localparam int STEP_W  = 4;

endpackage

// File: rtl/cfgld_strap_latch.sv
module cfgld_strap_latch
  import cfgld_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap,
  output logic [6:0]         dev_addr,
  output logic               addr_ok
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_addr <= '0;
      addr_ok  <= 1'b0;
    end else if (!addr_ok) begin
      dev_addr <= {DEV_FIXED, strap};
      addr_ok  <= 1'b1;
    end
  end

  // R1
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ok |=> $stable(dev_addr));

endmodule

// File: rtl/cfgld_rec_asm.sv
module cfgld_rec_asm #(
  parameter int NBYTES = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic [7:0]          byte_in,
  output logic [NBYTES*8-1:0] rec
);

  localparam int W = NBYTES * 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec <= '0;
    else if (shift_en) rec <= {rec[W-9:0], byte_in};
  end

endmodule

// File: rtl/cfgld_smb_txn.sv
module cfgld_smb_txn
  import cfgld_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_read,
  input  logic [15:0]      mem_addr,
  input  logic [7:0]       wdata,
  input  logic [LEN_W-1:0] rd_len,
  input  logic [6:0]       dev_addr,
  output logic             done,
  output logic             err,
  output logic             rd_valid,
  output logic [7:0]       rd_byte,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output smb_op_e          cmd_op,
  output logic [7:0]       cmd_data,
  input  logic             rsp_valid,
  input  logic             rsp_nack,
  input  logic [7:0]       rsp_data
);

  typedef enum logic [1:0] {T_IDLE, T_REQ, T_ISSUE, T_WAIT} tstate_e;

  tstate_e           state_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] last_step;
  logic              is_rd_q;
  logic [15:0]       addr_q;
  logic [7:0]        wdata_q;
  logic [LEN_W-1:0]  len_q;
  smb_op_e           op_c;
  logic [7:0]        data_c;

  assign last_step = is_rd_q ? (STEP_W'(6) + STEP_W'(len_q)) : STEP_W'(5);

  always_comb begin
    op_c   = SMB_WRITE;
    data_c = '0;
    if (step_q == last_step) begin
      op_c = SMB_STOP;
    end else begin
      case (step_q)
        4'd0: op_c = SMB_START;
        4'd1: data_c = {dev_addr, 1'b0};
        4'd2: data_c = addr_q[15:8];
        4'd3: data_c = addr_q[7:0];
        4'd4: begin
          if (is_rd_q) op_c = SMB_START;
          else data_c = wdata_q;
        end
        4'd5: data_c = {dev_addr, 1'b1};
        default: op_c = (step_q == last_step - STEP_W'(1)) ? SMB_READ_NACK : SMB_READ_ACK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= T_IDLE;
      step_q   <= '0;
      is_rd_q  <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      len_q    <= '0;
      err      <= 1'b0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rd_byte  <= '0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (state_q)
        T_IDLE: if (start) begin
          is_rd_q <= is_read;
          addr_q  <= mem_addr;
          wdata_q <= wdata;
          len_q   <= rd_len;
          step_q  <= '0;
          err     <= 1'b0;
          state_q <= T_REQ;
        end
        T_REQ: if (bus_gnt) state_q <= T_ISSUE;
        T_ISSUE: if (cmd_ready) state_q <= T_WAIT;
        T_WAIT: if (rsp_valid) begin
          if (op_c == SMB_WRITE && rsp_nack) begin
            err     <= 1'b1;
            step_q  <= last_step;
            state_q <= T_ISSUE;
          end else if (step_q == last_step) begin
            done    <= 1'b1;
            state_q <= T_IDLE;
          end else begin
            step_q  <= step_q + STEP_W'(1);
            state_q <= T_ISSUE;
          end
          if (op_c == SMB_READ_ACK || op_c == SMB_READ_NACK) begin
            rd_valid <= 1'b1;
            rd_byte  <= rsp_data;
          end
        end
        default: state_q <= T_IDLE;
      endcase
    end
  end

  assign bus_req   = (state_q != T_IDLE);
  assign cmd_valid = (state_q == T_ISSUE);
  assign cmd_op    = op_c;
  assign cmd_data  = data_c;

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data));

  // R8
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import cfgld_pkg::*;
#(
  parameter int MAX_RECS = 64,
  parameter int REG_AW   = 16,
  parameter int REG_DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        strap_addr,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [7:0]        cmd_data,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic [7:0]        rsp_data,
  output logic              reg_wr_valid,
  input  logic              reg_wr_ready,
  output logic [REG_AW-1:0] reg_wr_addr,
  output logic [REG_DW-1:0] reg_wr_data,
  input  logic              pt_req_valid,
  output logic              pt_req_ready,
  input  logic              pt_req_write,
  input  logic [15:0]       pt_req_addr,
  input  logic [7:0]        pt_req_wdata,
  output logic              pt_rsp_valid,
  input  logic              pt_rsp_ready,
  output logic [7:0]        pt_rsp_rdata,
  output logic              pt_rsp_err,
  output logic              load_done,
  output logic              load_err
);

  localparam int REC_BYTES = (REG_AW + REG_DW) / 8;
  localparam int REC_BITS  = REC_BYTES * 8;
  localparam int LEN_W     = $clog2(REC_BYTES + 1);
  localparam int CNT_W     = $clog2(MAX_RECS + 1);
  localparam logic [REG_AW-1:0] END_MARK = {REG_AW{1'b1}};

  typedef enum logic [2:0] {
    L_BOOT, L_FETCH, L_WAIT, L_PUSH, L_IDLE, P_WAIT, P_RSP
  } lstate_e;

  lstate_e          lstate_q;
  logic [6:0]       dev_addr;
  logic             addr_ok;
  logic [REC_BITS-1:0] rec;
  logic [15:0]      rec_base_q;
  logic [CNT_W-1:0] rec_cnt_q;
  logic             txn_start, txn_read, txn_done, txn_err, rd_valid;
  logic [7:0]       rd_byte;
  logic [15:0]      txn_addr;
  logic [LEN_W-1:0] txn_len;
  logic [7:0]       pt_rdata_q;
  logic             pt_err_q;
  smb_op_e          eng_op;

  cfgld_strap_latch u_strap (
    .clk(clk), .rst_n(rst_n), .strap(strap_addr),
    .dev_addr(dev_addr), .addr_ok(addr_ok)
  );

  cfgld_rec_asm #(.NBYTES(REC_BYTES)) u_rec (
    .clk(clk), .rst_n(rst_n), .shift_en(rd_valid), .byte_in(rd_byte), .rec(rec)
  );

  assign txn_start = (lstate_q == L_FETCH) || (lstate_q == L_IDLE && pt_req_valid);
  assign txn_read  = (lstate_q == L_IDLE) ? !pt_req_write : 1'b1;
  assign txn_addr  = (lstate_q == L_IDLE) ? pt_req_addr : rec_base_q;
  assign txn_len   = (lstate_q == L_IDLE) ? LEN_W'(1) : LEN_W'(REC_BYTES);

  cfgld_smb_txn #(.LEN_W(LEN_W)) u_txn (
    .clk(clk), .rst_n(rst_n), .start(txn_start), .is_read(txn_read),
    .mem_addr(txn_addr), .wdata(pt_req_wdata), .rd_len(txn_len), .dev_addr(dev_addr),
    .done(txn_done), .err(txn_err), .rd_valid(rd_valid), .rd_byte(rd_byte),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(eng_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_data(rsp_data)
  );

  assign cmd_op = eng_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lstate_q   <= L_BOOT;
      rec_base_q <= '0;
      rec_cnt_q  <= '0;
      load_done  <= 1'b0;
      load_err   <= 1'b0;
      pt_rdata_q <= '0;
      pt_err_q   <= 1'b0;
    end else begin
      case (lstate_q)
        L_BOOT:  if (addr_ok) lstate_q <= L_FETCH;
        L_FETCH: lstate_q <= L_WAIT;
        L_WAIT: if (txn_done) begin
          if (txn_err) begin
            load_done <= 1'b1;
            load_err  <= 1'b1;
            lstate_q  <= L_IDLE;
          end else if (rec[REC_BITS-1 -: REG_AW] == END_MARK) begin
            load_done <= 1'b1;
            lstate_q  <= L_IDLE;
          end else begin
            lstate_q  <= L_PUSH;
          end
        end
        L_PUSH: if (reg_wr_ready) begin
          rec_base_q <= rec_base_q + 16'(REC_BYTES);
          rec_cnt_q  <= rec_cnt_q + CNT_W'(1);
          if (rec_cnt_q == CNT_W'(MAX_RECS - 1)) begin
            load_done <= 1'b1;
            load_err  <= 1'b1;
            lstate_q  <= L_IDLE;
          end else begin
            lstate_q  <= L_FETCH;
          end
        end
        L_IDLE: if (pt_req_valid) begin
          pt_rdata_q <= '0;
          lstate_q   <= P_WAIT;
        end
        P_WAIT: begin
          if (rd_valid) pt_rdata_q <= rd_byte;
          if (txn_done) begin
            pt_err_q <= txn_err;
            lstate_q <= P_RSP;
          end
        end
        P_RSP: if (pt_rsp_ready) lstate_q <= L_IDLE;
        default: lstate_q <= L_IDLE;
      endcase
    end
  end

  assign reg_wr_valid = (lstate_q == L_PUSH);
  assign reg_wr_addr  = rec[REC_BITS-1 -: REG_AW];
  assign reg_wr_data  = rec[REG_DW-1:0];
  assign pt_req_ready = (lstate_q == L_IDLE);
  assign pt_rsp_valid = (lstate_q == P_RSP);
  assign pt_rsp_rdata = pt_rdata_q;
  assign pt_rsp_err   = pt_err_q;

  // R13
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid && !reg_wr_ready |=> reg_wr_valid && $stable(reg_wr_addr) && $stable(reg_wr_data));

  // R12
  pt_rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rsp_valid && !pt_rsp_ready |=> pt_rsp_valid && $stable(pt_rsp_rdata) && $stable(pt_rsp_err));

  // R9
  pt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pt_req_ready |-> load_done);

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);

endmodule

// File: tb/eeprom_cfg_loader_tb_top.sv
module eeprom_cfg_loader_tb_top;

  localparam int NREC = 3;
  localparam logic [47:0] RECS [NREC] = '{
    48'h0010_DEADBEEF,
    48'h0124_00000001,
    48'hABCD_80000000
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  strap_addr = 4'b0110;
  logic        bus_req, bus_gnt = 1'b0;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_data;
  logic        rsp_valid = 1'b0, rsp_nack = 1'b0;
  logic [7:0]  rsp_data = '0;
  logic        reg_wr_valid, reg_wr_ready = 1'b0;
  logic [15:0] reg_wr_addr;
  logic [31:0] reg_wr_data;
  logic        pt_req_valid = 1'b0, pt_req_ready, pt_req_write = 1'b0;
  logic [15:0] pt_req_addr = '0;
  logic [7:0]  pt_req_wdata = '0;
  logic        pt_rsp_valid, pt_rsp_ready = 1'b0;
  logic [7:0]  pt_rsp_rdata;
  logic        pt_rsp_err, load_done, load_err;

  always #2.5 clk = ~clk;

  eeprom_cfg_loader #(.MAX_RECS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_data(rsp_data),
    .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .pt_req_valid(pt_req_valid), .pt_req_ready(pt_req_ready), .pt_req_write(pt_req_write),
    .pt_req_addr(pt_req_addr), .pt_req_wdata(pt_req_wdata),
    .pt_rsp_valid(pt_rsp_valid), .pt_rsp_ready(pt_rsp_ready),
    .pt_rsp_rdata(pt_rsp_rdata), .pt_rsp_err(pt_rsp_err),
    .load_done(load_done), .load_err(load_err)
  );

  int checks = 0;
  int fails  = 0;

  // EEPROM and bus environment model
  logic [7:0]  mem [256];
  logic [6:0]  model_dev = 7'b1010110;
  int          nack_dev_cnt = 0;
  int          dev_cnt = 0;
  int          wcnt = 0;
  logic [15:0] ptr = '0;
  logic        pend = 1'b0, p_nack = 1'b0;
  logic [7:0]  p_data = '0;
  logic [2:0]  log_op [256];
  logic [7:0]  log_dat [256];
  int          log_n = 0;
  logic [15:0] wr_addr [16];
  logic [31:0] wr_data [16];
  int          wr_n = 0;
  int          req_rises = 0;
  int          nogrant = 0;
  logic        req_prev = 1'b0;
  int          cyc = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic model_cmd();
    p_nack = 1'b0;
    p_data = '0;
    case (cmd_op)
      3'd0: wcnt = 0;
      3'd1: begin
        if (wcnt == 0) begin
          dev_cnt++;
          p_nack = (cmd_data[7:1] != model_dev) || (dev_cnt == nack_dev_cnt);
        end else if (wcnt == 1) ptr[15:8] = cmd_data;
        else if (wcnt == 2) ptr[7:0] = cmd_data;
        else begin
          mem[ptr[7:0]] = cmd_data;
          ptr = ptr + 16'd1;
        end
        wcnt++;
      end
      3'd2, 3'd3: begin
        p_data = mem[ptr[7:0]];
        ptr = ptr + 16'd1;
      end
      default: ;
    endcase
    if (log_n < 256) begin
      log_op[log_n]  = cmd_op;
      log_dat[log_n] = cmd_data;
      log_n++;
    end
    pend = 1'b1;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!bus_req) bus_gnt = 1'b0;
      else if (!bus_gnt && (cyc % 5 == 0)) bus_gnt = 1'b1;
      if (bus_req && !req_prev) req_rises++;
      req_prev = bus_req;
      if (cmd_valid && !bus_gnt) nogrant++;
      rsp_valid = 1'b0;
      if (pend) begin
        rsp_valid = 1'b1;
        rsp_nack  = p_nack;
        rsp_data  = p_data;
        pend      = 1'b0;
      end
      cmd_ready = (cyc % 3 != 1);
      if (cmd_valid && cmd_ready) model_cmd();
      reg_wr_ready = (cyc % 2 == 0);
      if (reg_wr_valid && reg_wr_ready && wr_n < 16) begin
        wr_addr[wr_n] = reg_wr_addr;
        wr_data[wr_n] = reg_wr_data;
        wr_n++;
      end
    end
  end

  task automatic load_table(input bit with_end);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int r = 0; r < NREC; r++)
      for (int b = 0; b < 6; b++) mem[r*6+b] = RECS[r][47-8*b -: 8];
    if (with_end) begin
      mem[NREC*6]   = 8'hFF;
      mem[NREC*6+1] = 8'hFF;
    end
  endtask

  task automatic do_reset(input logic [3:0] straps);
    @(negedge clk);
    rst_n = 1'b0;
    strap_addr = straps;
    dev_cnt = 0; wcnt = 0; pend = 1'b0; log_n = 0; wr_n = 0; req_rises = 0; nogrant = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 6000 && !load_done; i++) @(negedge clk);
  endtask

  task automatic pt_access(input logic wr, input logic [15:0] a, input logic [7:0] d,
                           output logic [7:0] rdata, output logic err);
    pt_req_write = wr; pt_req_addr = a; pt_req_wdata = d; pt_req_valid = 1'b1;
    for (int i = 0; i < 100 && !pt_req_ready; i++) @(negedge clk);
    @(negedge clk);
    pt_req_valid = 1'b0;
    for (int i = 0; i < 2000 && !pt_rsp_valid; i++) @(negedge clk);
    rdata = pt_rsp_rdata;
    err   = pt_rsp_err;
    repeat (3) @(negedge clk);
    check("R12 response held valid", {63'd0, pt_rsp_valid}, 64'd1);
    check("R12 response data held", {56'd0, pt_rsp_rdata}, {56'd0, rdata});
    pt_rsp_ready = 1'b1;
    @(negedge clk);
    pt_rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       er;
    // Main load: table of records walked by one loop
    load_table(1'b1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 reset state pt_req_ready", {63'd0, pt_req_ready}, 64'd0);
    check("R4 reset state load_done", {63'd0, load_done}, 64'd0);
    check("R8 reset state bus_req", {63'd0, bus_req}, 64'd0);
    check("R13 reset state reg_wr_valid", {63'd0, reg_wr_valid}, 64'd0);
    do_reset(4'b0110);
    repeat (2) @(negedge clk);
    strap_addr = 4'b1111;  // R1: late strap change ignored
    repeat (10) @(negedge clk);
    check("R9 closed during load", {63'd0, pt_req_ready}, 64'd0);
    wait_done();
    check("R4 load_done", {63'd0, load_done}, 64'd1);
    check("R4 load_err clear", {63'd0, load_err}, 64'd0);
    check("R3 write count", 64'(wr_n), 64'(NREC));
    for (int r = 0; r < NREC; r++) begin
      check("R3 register address", {48'd0, wr_addr[r]}, {48'd0, RECS[r][47:32]});
      check("R3 register data", {32'd0, wr_data[r]}, {32'd0, RECS[r][31:0]});
    end
    check("R1 device write byte", {56'd0, log_dat[1]}, 64'hAC);
    check("R1 device read byte", {56'd0, log_dat[5]}, 64'hAD);
    check("R2 fetch op 0 START", {61'd0, log_op[0]}, 64'd0);
    check("R2 fetch op 4 START", {61'd0, log_op[4]}, 64'd0);
    check("R2 fetch op 6 READ_ACK", {61'd0, log_op[6]}, 64'd2);
    check("R2 fetch op 11 READ_NACK", {61'd0, log_op[11]}, 64'd3);
    check("R2 fetch op 12 STOP", {61'd0, log_op[12]}, 64'd4);
    check("R2 second record addr low", {56'd0, log_dat[13+3]}, 64'd6);
    check("R7 one command per response", 64'(log_n), 64'((NREC + 1) * 13));
    check("R8 one request per record", 64'(req_rises), 64'(NREC + 1));
    check("R8 no command without grant", 64'(nogrant), 64'd0);
    check("R9 open after load", {63'd0, pt_req_ready}, 64'd1);

    // Pass-through write then read
    log_n = 0;
    pt_access(1'b1, 16'h0040, 8'h5A, rd, er);
    check("R10 write err", {63'd0, er}, 64'd0);
    check("R10 write commands", 64'(log_n), 64'd6);
    check("R10 data byte", {56'd0, log_dat[4]}, 64'h5A);
    check("R10 addr low byte", {56'd0, log_dat[3]}, 64'h40);
    check("R10 last op STOP", {61'd0, log_op[5]}, 64'd4);
    check("R10 EEPROM updated", {56'd0, mem[8'h40]}, 64'h5A);
    log_n = 0;
    pt_access(1'b0, 16'h0040, 8'h00, rd, er);
    check("R11 read data", {56'd0, rd}, 64'h5A);
    check("R11 read err", {63'd0, er}, 64'd0);
    check("R11 read commands", 64'(log_n), 64'd8);
    check("R11 single READ_NACK", {61'd0, log_op[6]}, 64'd3);
    check("R11 repeated START", {61'd0, log_op[4]}, 64'd0);

    // NACK on second record: first record kept, second dropped
    load_table(1'b1);
    nack_dev_cnt = 3;
    do_reset(4'b0110);
    wait_done();
    nack_dev_cnt = 0;
    check("R5 done on nack", {63'd0, load_done}, 64'd1);
    check("R5 err on nack", {63'd0, load_err}, 64'd1);
    check("R5 only first record written", 64'(wr_n), 64'd1);
    check("R5 STOP after nack", {61'd0, log_op[log_n-1]}, 64'd4);
    check("R5 nack transaction length", 64'(log_n), 64'(13 + 3));

    // Record limit with no end marker
    for (int i = 0; i < 256; i++) mem[i] = 8'(i + 1);
    do_reset(4'b0110);
    wait_done();
    check("R6 err at limit", {63'd0, load_err}, 64'd1);
    check("R6 writes at limit", 64'(wr_n), 64'd4);
    check("R6 first addr", {48'd0, wr_addr[0]}, 64'h0102);
    check("R6 last data", {32'd0, wr_data[3]}, 64'h15161718);

    // Strap mismatch: device refuses, no writes; pass-through then errors
    load_table(1'b1);
    do_reset(4'b0011);
    wait_done();
    check("R1 mismatched device byte", {56'd0, log_dat[1]}, 64'hA6);
    check("R5 err on device nack", {63'd0, load_err}, 64'd1);
    check("R5 no writes", 64'(wr_n), 64'd0);
    pt_access(1'b0, 16'h0003, 8'h00, rd, er);
    check("R12 pass-through nack err", {63'd0, er}, 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule